// File: doc/BRIEF.md
# Accumulator Processor with Compare-Driven Branches

This block is a small multi-cycle processor built around one 16-bit accumulator. It fetches 16-bit instruction words from a word-addressed memory inside the block, then decodes and executes them. Every instruction takes three clock cycles: fetch, decode and execute. The instruction set covers the following:

- loads, stores, addition and subtraction against memory;
- reads from an input port bus and writes to an output port bus;
- an unconditional jump and a jump taken when the accumulator is negative;
- a compare instruction whose latched greater, equal and less results steer three later conditional jumps;
- a halt instruction that parks the machine.

The program is placed in the memory array before reset is released. The block talks to the outside only through its two port buses and its halt flag.

Top module: `acpu_core`

## Requirements
- R1: While reset is low and in the first cycle after release, `halted`, `in_rd` and `out_wr` are low, and execution begins by fetching the word at address 0.
- R2: An instruction word holds the opcode in bits 15:12 and the operand in bits 11:0. Each instruction uses exactly three cycles: fetch, decode and execute. The program counter advances by one at fetch.
- R3: Opcode 1 loads the accumulator from memory at the operand address. Opcode 2 stores the accumulator there. The memory index is the operand's low log2(MEM_DEPTH) bits.
- R4: Opcode 3 adds the memory word to the accumulator and opcode 4 subtracts it. Both use two's-complement arithmetic that wraps modulo 2^16.
- R5: Opcode 5 raises `in_rd` for exactly the execute cycle, with `in_port` equal to the operand, and loads the accumulator from `in_data` at the end of that cycle.
- R6: Opcode 6 raises `out_wr` for one cycle, in the cycle after execute. In that cycle `out_port` equals the operand and `out_data` equals the accumulator.
- R7: Opcode 7 always loads the program counter with the operand.
- R8: Opcode 8 jumps to the operand exactly when accumulator bit 15 is 1. Otherwise execution falls through.
- R9: Opcode A compares the accumulator with the memory word as signed numbers. It latches exactly one of the flags greater, equal or less, and it leaves the accumulator unchanged.
- R10: Opcodes B, C and D jump when the latched greater, equal or less flag is set, respectively. After reset no flag is set, so none of them jumps.
- R11: Opcode 9 raises `halted` from the cycle after its execute until reset. While halted, the program counter holds its value and no strobe fires.
- R12: Opcodes 0, E and F change no state and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 16 | Data on the input port bus |
| in_port | output | 12 | Port number of the current input read |
| in_rd | output | 1 | Input read strobe, high during the execute cycle |
| out_port | output | 12 | Port number of the last output write |
| out_data | output | 16 | Accumulator value of the last output write |
| out_wr | output | 1 | One-cycle output write strobe |
| halted | output | 1 | High once a halt has executed |

## Verification
The bench runs a reference model in lock-step with the design and compares the strobes, the port buses and the halt flag on every clock. It targets the following corner cases:

- **Signed overflow wrap on addition:** an adder that saturates would output the wrong value.
- **A compare of a negative accumulator against a positive word:** an unsigned comparator would report greater and take the wrong jump.
- **Jumps guarded by flags in a freshly reset machine:** a design whose flags come up wrong would branch into a trap that emits an unexpected write.
- **Store-then-reload, reserved opcodes, and words placed after a halt:** a design that mishandles these would corrupt the accumulator or keep issuing writes.

// File: rtl/acpu_pkg.sv
package acpu_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP = 4'h0, OP_LDA, OP_STA, OP_ADD, OP_SUB, OP_IN, OP_OUT, OP_JMP,
      OP_JN, OP_HLT, OP_CMP, OP_JG, OP_JE, OP_JL, OP_RSV_E, OP_RSV_F
   } opcode_e;

   typedef enum logic [1:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_HALT} state_e;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cmp_flags_t;
endpackage

// File: rtl/acpu_mem.sv
module acpu_mem #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/acpu_alu.sv
module acpu_alu import acpu_pkg::*; #(
   parameter int DATA_W     = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] result,
   output cmp_flags_t        flags
);
   assign result = sub ? (a - b) : (a + b);
   assign flags.eq = (a == b);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign flags.gt = $signed(a) > $signed(b);
         assign flags.lt = $signed(a) < $signed(b);
      end else begin : g_unsigned
         assign flags.gt = a > b;
         assign flags.lt = a < b;
      end
   endgenerate
endmodule

// File: rtl/acpu_ctrl.sv
module acpu_ctrl import acpu_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 8,
   localparam int OPND_W = DATA_W - OPC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              acc_neg,
   input  cmp_flags_t        flags,
   output state_e            state,
   output opcode_e           opcode,
   output logic [OPND_W-1:0] operand,
   output logic [OPND_W-1:0] pc,
   output logic [IDX_W-1:0]  mem_raddr
);
   logic [DATA_W-1:0] ir;
   logic              take_jump;

   assign opcode  = opcode_e'(ir[DATA_W-1 -: OPC_W]);
   assign operand = ir[OPND_W-1:0];

   always_comb begin
      case (opcode)
         OP_JMP:  take_jump = 1'b1;
         OP_JN:   take_jump = acc_neg;
         OP_JG:   take_jump = flags.gt;
         OP_JE:   take_jump = flags.eq;
         OP_JL:   take_jump = flags.lt;
         default: take_jump = 1'b0;
      endcase
   end

   assign mem_raddr = (state == ST_FETCH) ? pc[IDX_W-1:0] : operand[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_FETCH;
         pc    <= '0;
         ir    <= '0;
      end else begin
         case (state)
            ST_FETCH: begin
               ir    <= mem_rdata;
               pc    <= pc + 1'b1;
               state <= ST_DECODE;
            end
            ST_DECODE: state <= ST_EXEC;
            ST_EXEC: begin
               if (take_jump) pc <= operand;
               state <= (opcode == OP_HLT) ? ST_HALT : ST_FETCH;
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   AST_FETCH_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && opcode != OP_HLT) |=> (state == ST_FETCH)); // R2
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1)); // R2
endmodule

// File: rtl/acpu_core.sv
module acpu_core import acpu_pkg::*; #(
   parameter int DATA_W     = 16,
   parameter int MEM_DEPTH  = 256,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-5:0] in_port,
   output logic              in_rd,
   output logic [DATA_W-5:0] out_port,
   output logic [DATA_W-1:0] out_data,
   output logic              out_wr,
   output logic              halted
);
   localparam int OPND_W = DATA_W - OPC_W;
   localparam int IDX_W  = $clog2(MEM_DEPTH);

   generate
      if (OPC_W != 4) begin : g_bad_opc
         $error("opcode map needs a 4-bit field");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W too small");
      end
      if (MEM_DEPTH < 2 || (MEM_DEPTH & (MEM_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("MEM_DEPTH must be a power of two");
      end
      if (IDX_W > OPND_W) begin : g_bad_reach
         $error("memory deeper than operand reach");
      end
   endgenerate

   state_e            state;
   opcode_e           opcode;
   logic [OPND_W-1:0] operand, pc;
   logic [IDX_W-1:0]  mem_raddr;
   logic [DATA_W-1:0] mem_rdata, acc, mdr, alu_res;
   cmp_flags_t        flags, alu_flags;
   logic              exec, mem_we;

   assign exec   = (state == ST_EXEC);
   assign mem_we = exec && (opcode == OP_STA);

   acpu_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
      .clk(clk), .rd_addr(mem_raddr), .rd_data(mem_rdata),
      .wr_en(mem_we), .wr_addr(operand[IDX_W-1:0]), .wr_data(acc));

   acpu_alu #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_alu (
      .a(acc), .b(mdr), .sub(opcode != OP_ADD),
      .result(alu_res), .flags(alu_flags));

   acpu_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .acc_neg(acc[DATA_W-1]),
      .flags(flags), .state(state), .opcode(opcode), .operand(operand),
      .pc(pc), .mem_raddr(mem_raddr));

   assign in_rd   = exec && (opcode == OP_IN);
   assign in_port = operand;
   assign halted  = (state == ST_HALT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc      <= '0;
         mdr      <= '0;
         flags    <= '0;
         out_port <= '0;
         out_data <= '0;
         out_wr   <= 1'b0;
      end else begin
         out_wr <= 1'b0;
         if (state == ST_DECODE) mdr <= mem_rdata;
         if (exec) begin
            case (opcode)
               OP_LDA:          acc <= mdr;
               OP_ADD, OP_SUB:  acc <= alu_res;
               OP_IN:           acc <= in_data;
               OP_CMP:          flags <= alu_flags;
               OP_OUT: begin
                  out_wr   <= 1'b1;
                  out_port <= operand;
                  out_data <= acc;
               end
               default: ;
            endcase
         end
      end
   end

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flags)); // R9
   AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && opcode == OP_CMP) |=> $stable(acc)); // R9
   AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |=> !out_wr); // R6
   AST_IN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_rd |=> !in_rd); // R5
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R11
   AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc)); // R11
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !in_rd); // R11
endmodule

// File: tb/acpu_core_tb.sv
module acpu_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] in_data;
   logic [11:0] in_port, out_port;
   logic [15:0] out_data;
   logic        in_rd, out_wr, halted;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   acpu_core u_dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_port(in_port), .in_rd(in_rd),
      .out_port(out_port), .out_data(out_data), .out_wr(out_wr), .halted(halted));

   function automatic logic [15:0] stim(input logic [11:0] p);
      return {p[3:0], p} ^ 16'h5A00;
   endfunction
   assign in_data = stim(in_port);

   // ---------------- reference model ----------------
   logic [15:0] mmem [256];
   int          m_pc, m_phase;
   logic [15:0] m_acc;
   bit          m_gt, m_eq, m_lt, m_halt;
   bit          e_wr;
   logic [11:0] e_port;
   logic [15:0] e_data;

   task automatic m_exec();
      logic [15:0] ins, opv;
      logic [3:0]  op;
      logic [11:0] opd;
      ins = mmem[m_pc];
      op  = ins[15:12];
      opd = ins[11:0];
      opv = mmem[opd[7:0]];
      m_pc = (m_pc + 1) % 4096;
      case (op)
         4'h1: m_acc = opv;
         4'h2: mmem[opd[7:0]] = m_acc;
         4'h3: m_acc = m_acc + opv;
         4'h4: m_acc = m_acc - opv;
         4'h5: m_acc = stim(opd);
         4'h6: begin e_wr = 1'b1; e_port = opd; e_data = m_acc; end
         4'h7: m_pc = opd;
         4'h8: if (m_acc[15]) m_pc = opd;
         4'h9: m_halt = 1'b1;
         4'hA: begin
            m_gt = $signed(m_acc) > $signed(opv);
            m_eq = m_acc == opv;
            m_lt = $signed(m_acc) < $signed(opv);
         end
         4'hB: if (m_gt) m_pc = opd;
         4'hC: if (m_eq) m_pc = opd;
         4'hD: if (m_lt) m_pc = opd;
         default: ;
      endcase
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_pc = 0; m_phase = 0; m_acc = '0;
         m_gt = 0; m_eq = 0; m_lt = 0; m_halt = 0; e_wr = 0;
      end else begin
         e_wr = 1'b0;
         if (!m_halt) begin
            if (m_phase < 2) m_phase++;
            else begin
               m_phase = 0;
               m_exec();
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // per-clock comparison, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic exp_rd;
         exp_rd = !m_halt && (m_phase == 2) && (mmem[m_pc][15:12] == 4'h5);
         check(halted == m_halt, "R11", "halted", 32'(halted), 32'(m_halt));
         check(in_rd == exp_rd, "R2,R5", "in_rd", 32'(in_rd), 32'(exp_rd));
         check(out_wr == e_wr, "R2,R6", "out_wr", 32'(out_wr), 32'(e_wr));
         if (exp_rd)
            check(in_port == mmem[m_pc][11:0], "R5", "in_port", 32'(in_port),
                  32'(mmem[m_pc][11:0]));
         if (e_wr && out_wr) begin
            check(out_port == e_port, "R6", "out_port", 32'(out_port), 32'(e_port));
            // the output port number names the requirement a write exercises
            check(out_data == e_data, $sformatf("R%0d", e_port), "out_data",
                  32'(out_data), 32'(e_data));
         end
      end
   end

   task automatic put(input int a, input logic [15:0] w);
      u_dut.u_mem.mem[a] = w;
      mmem[a] = w;
   endtask

   task automatic run_program();
      int n;
      @(negedge clk);
      check(!halted && !in_rd && !out_wr, "R1", "idle outputs in reset",
            {29'd0, halted, in_rd, out_wr}, 32'd0);
      rst_n = 1'b1;
      check(!halted && !in_rd && !out_wr, "R1", "idle outputs after release",
            {29'd0, halted, in_rd, out_wr}, 32'd0);
      n = 0;
      while (!m_halt && n < 3000) begin @(negedge clk); n++; end
      repeat (12) @(negedge clk);
      check(m_halt, "R11", "program reached halt", 32'(m_halt), 32'd1);
   endtask

   initial begin : main
      for (int i = 0; i < 256; i++) put(i, 16'h0000);
      // data words
      put(8'hC0, 16'h0005); put(8'hC1, 16'h0003); put(8'hC2, 16'h7FFF);
      put(8'hC3, 16'h0001); put(8'hC4, 16'hFFFE); put(8'hC5, 16'h0000);
      // program 1
      put(0,  16'h10C0); put(1, 16'h30C1); put(2, 16'h6004);   // R4 5+3
      put(3,  16'h40C0); put(4, 16'h40C0); put(5, 16'h6004);   // R4 subtract below zero
      put(6,  16'h10C2); put(7, 16'h30C3); put(8, 16'h6004);   // R4 wrap to 8000
      put(9,  16'h20C5); put(10, 16'h10C0); put(11, 16'h10C5);
      put(12, 16'h6003);                                        // R3 store then reload
      put(13, 16'h50AB); put(14, 16'h6005);                     // R5 port read
      put(15, 16'h10C4); put(16, 16'h8012); put(17, 16'h6EEE); // R8 taken
      put(18, 16'h10C0); put(19, 16'h8015); put(20, 16'h6008); // R8 not taken
      put(21, 16'h7017); put(22, 16'h6EEE); put(23, 16'h6007); // R7
      put(24, 16'h10C0); put(25, 16'hA0C1);                     // R9 greater
      put(26, 16'hC01D); put(27, 16'hD01D); put(28, 16'hB01E);
      put(29, 16'h6EEE); put(30, 16'h600A);                     // R10, acc kept
      put(31, 16'hA0C0); put(32, 16'hB023); put(33, 16'hC023); // R9 equal
      put(34, 16'h6EEE);
      put(35, 16'h10C4); put(36, 16'hA0C1);                     // R9 signed less
      put(37, 16'hD027); put(38, 16'h6EEE); put(39, 16'h6009);
      put(40, 16'h0123); put(41, 16'hE123); put(42, 16'hF456); // R12
      put(43, 16'h600C);
      put(44, 16'h9000); put(45, 16'h600B);                     // R11 no write after halt
      run_program();

      // program 2: fresh reset, flags clear (R1, R10)
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      put(0, 16'hB005); put(1, 16'hC005); put(2, 16'hD005);
      put(3, 16'h600A); put(4, 16'h9000); put(5, 16'h6EEE); put(6, 16'h9000);
      run_program();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      done = 1'b1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule